// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Receiver

This block is the programming front end of a clock synthesizer with several divider register sets. It watches a slow serial clock and data pin pair from the host. Both pins pass through a synchronizer into the system clock domain. The receiver ignores everything until it sees an unlock sequence: five or more consecutive ones, each sampled on a serial clock rising edge, followed by a single zero start bit.

Once unlocked, it collects a fixed 26-bit word, least significant bit first, and drops the first bit by shifting the word right one place. The 3-bit address near the top of the word picks the target. Addresses 0 to 2 load a frequency register set made of P', M and Q'. Address 6 loads an 8-bit control byte. Every other address is discarded. After each complete word the receiver locks itself again, so the next word needs a fresh unlock sequence.

For each frequency set, the block presents the stored fields, the effective feedback divider (P' + 3) and the post-divider (2^M). It also presents the control byte.

Top module: `scp_prog_rx`

## Requirements
- R1: While locked, a zero that arrives after five or more consecutive ones unlocks the receiver and is itself consumed as the start bit. A zero that arrives after fewer than five ones leaves the receiver locked and restarts the ones count.
- R2: While unlocked, a word is complete after exactly 26 accepted bits. The k-th bit received is raw bit k (the first bit is raw bit 0). The decoded word equals the raw word shifted right by one, so decoded bit j = raw bit j+1.
- R3: The target address is decoded bits 24:22 (raw bits 25:23).
- R4: Addresses 0, 1 and 2 load that set's P' from decoded bits 17:11, M from bits 10:8 and Q' from bits 7:1.
- R5: Each set's feedback divider output (8 bits) equals its P' plus 3.
- R6: Each set's post-divider output (8 bits) equals 2 to the power M, so exactly one bit is set.
- R7: Address 6 loads the control byte from decoded bits 20:13 and leaves all frequency sets unchanged.
- R8: Addresses 3, 4, 5 and 7 change no output.
- R9: The 4-bit index field at decoded bits 21:18 has no effect on any output.
- R10: After every complete word the receiver returns to the locked state with its bit, shift and ones counters cleared. Bits sent without a new unlock sequence write nothing.
- R11: After synchronous active-low reset, every set holds P' = 25, M = 2 and Q' = 20, the control byte is 0, and the receiver is locked.
- R12: Each serial clock rising edge delivers exactly one bit, however long the serial clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Asynchronous serial programming clock |
| ser_data_i | input | 1 | Asynchronous serial programming data |
| pprime_o | output | 21 | P' of each set, set k at bits 7k+6:7k |
| mexp_o | output | 9 | M of each set, set k at bits 3k+2:3k |
| qprime_o | output | 21 | Q' of each set, set k at bits 7k+6:7k |
| pdiv_o | output | 24 | P' + 3 per set, set k at bits 8k+7:8k |
| postdiv_o | output | 24 | 2^M per set, set k at bits 8k+7:8k |
| ctrl_o | output | 8 | Control byte |

## Verification
A serial clock rising edge reaches the edge detector after the two synchronizer flops. The framer registers the completed word one cycle later, and the register bank updates on the next cycle. A stored field is therefore due four system cycles after the rising edge of the 26th bit, and the divider outputs follow on the same cycle because they are combinational. The bench holds each data bit steady for three cycles before the serial clock rises and for the whole high phase. It waits eight cycles after the last bit of a sequence before it samples any output. It samples on the falling system clock edge.

// File: rtl/scp_pkg.sv
// Package: field layout and widths of the serial programming word.
// Assumes the decoded word (after the one-place right shift) is WORD_BITS-1 wide.
package scp_pkg;
    localparam int WORD_BITS = 26;            // raw serial bits per word
    localparam int DEC_BITS  = WORD_BITS - 1; // decoded word width
    localparam int AW        = 3;             // address width
    localparam int ADDR_LSB  = 22;
    localparam int IW        = 4;             // index field width
    localparam int IDX_LSB   = 18;
    localparam int PW        = 7;             // P' width
    localparam int PP_LSB    = 11;
    localparam int MW        = 3;             // M width
    localparam int M_LSB     = 8;
    localparam int QW        = 7;             // Q' width
    localparam int QP_LSB    = 1;
    localparam int CW        = 8;             // control byte width
    localparam int CTRL_LSB  = 13;
    localparam int CTRL_ADDR = 6;
    localparam int NUM_FREQ  = 3;             // frequency register sets
    localparam int P_OFFSET  = 3;             // effective P = P' + P_OFFSET
    localparam int PDW       = PW + 1;        // effective P width
    localparam int PSW       = 1 << MW;       // post-divider width

    typedef logic [DEC_BITS-1:0] dec_word_t;
endpackage

// File: rtl/scp_edge_sync.sv
// Module: scp_edge_sync
// Brings the serial clock and data pins into the system clock domain and
// emits a single-cycle strobe for every serial clock rising edge, with the
// data value that was sampled alongside it.
// Assumes the serial clock is much slower than clk (each level held for
// several system cycles) and that data is stable around its rising edge.
module scp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_data_i,
    output logic bit_stb_o,
    output logic bit_val_o
);
    logic [STAGES-1:0] ck_sh;
    logic [STAGES-1:0] dt_sh;
    logic              ck_prev;

    // Synchronizer chains for both pins plus the previous clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_sh   <= '0;
            dt_sh   <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_sh   <= {ck_sh[STAGES-2:0], ser_clk_i};
            dt_sh   <= {dt_sh[STAGES-2:0], ser_data_i};
            ck_prev <= ck_sh[STAGES-1];
        end
    end

    // Rising edge of the synchronized serial clock.
    assign bit_stb_o = ck_sh[STAGES-1] & ~ck_prev;
    assign bit_val_o = dt_sh[STAGES-1];

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o); // R12
endmodule

// File: rtl/scp_frame.sv
// Module: scp_frame
// Unlock detector and word framer. While locked it counts consecutive ones
// and unlocks on a zero that follows enough of them. While unlocked it
// collects WORD_BITS bits, drops the first one, presents the decoded word for
// one cycle and locks again.
// Assumes bit_stb_i is a single-cycle strobe carrying bit_val_i.
module scp_frame
    import scp_pkg::*;
#(
    parameter int UNLOCK_ONES = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_stb_i,
    input  logic      bit_val_i,
    output logic      word_stb_o,
    output dec_word_t word_o
);
    localparam int OW  = $clog2(UNLOCK_ONES + 1);
    localparam int BCW = $clog2(WORD_BITS);
    localparam int SHW = WORD_BITS - 2;

    logic           unlocked;
    logic [OW-1:0]  ones_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [SHW-1:0] shreg;

    // Lock state machine, ones counter, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked   <= 1'b0;
            ones_cnt   <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            word_stb_o <= 1'b0;
            word_o     <= '0;
        end else begin
            word_stb_o <= 1'b0;
            if (bit_stb_i) begin
                if (!unlocked) begin
                    if (bit_val_i) begin
                        if (ones_cnt != OW'(UNLOCK_ONES))
                            ones_cnt <= ones_cnt + 1'b1;
                    end else begin
                        ones_cnt <= '0;
                        if (ones_cnt == OW'(UNLOCK_ONES))
                            unlocked <= 1'b1;
                    end
                end else if (bit_cnt == BCW'(WORD_BITS - 1)) begin
                    word_o     <= {bit_val_i, shreg};
                    word_stb_o <= 1'b1;
                    unlocked   <= 1'b0;
                    ones_cnt   <= '0;
                    bit_cnt    <= '0;
                    shreg      <= '0;
                end else begin
                    shreg   <= {bit_val_i, shreg[SHW-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < BCW'(WORD_BITS)); // R2
    AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= OW'(UNLOCK_ONES)); // R1
    AST_ZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_i && !unlocked && !bit_val_i && ones_cnt < OW'(UNLOCK_ONES))
        |=> (!unlocked && ones_cnt == '0)); // R1
    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> (!unlocked && bit_cnt == '0 && ones_cnt == '0)); // R10
    AST_WORD_FROM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_stb_o) |-> $past(unlocked)); // R2
endmodule

// File: rtl/scp_reg_bank.sv
// Module: scp_reg_bank
// Decodes a framed word by its address and updates one frequency register
// set or the control byte. Presents stored fields, effective P and 2^M.
// Assumes word_stb_i is a single-cycle strobe with word_i valid alongside.
module scp_reg_bank
    import scp_pkg::*;
#(
    parameter logic [PW-1:0] DEF_PP = 7'd25,
    parameter logic [MW-1:0] DEF_M  = 3'd2,
    parameter logic [QW-1:0] DEF_QP = 7'd20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_stb_i,
    input  dec_word_t               word_i,
    output logic [NUM_FREQ*PW-1:0]  pprime_o,
    output logic [NUM_FREQ*MW-1:0]  mexp_o,
    output logic [NUM_FREQ*QW-1:0]  qprime_o,
    output logic [NUM_FREQ*PDW-1:0] pdiv_o,
    output logic [NUM_FREQ*PSW-1:0] postdiv_o,
    output logic [CW-1:0]           ctrl_o
);
    logic [AW-1:0] addr;
    logic [IW-1:0] index_fld;
    logic [CW-1:0] ctrl_q;

    // Field extraction from the decoded word.
    assign addr      = word_i[ADDR_LSB +: AW];
    assign index_fld = word_i[IDX_LSB +: IW];

    genvar g;
    generate
        for (g = 0; g < NUM_FREQ; g++) begin : g_set
            logic [PW-1:0] pp_q;
            logic [MW-1:0] m_q;
            logic [QW-1:0] qp_q;

            // Loads this set when the word addresses it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pp_q <= DEF_PP;
                    m_q  <= DEF_M;
                    qp_q <= DEF_QP;
                end else if (word_stb_i && addr == AW'(g)) begin
                    pp_q <= word_i[PP_LSB +: PW];
                    m_q  <= word_i[M_LSB +: MW];
                    qp_q <= word_i[QP_LSB +: QW];
                end
            end

            // Effective dividers derived from the stored fields.
            assign pprime_o[g*PW +: PW]    = pp_q;
            assign mexp_o[g*MW +: MW]      = m_q;
            assign qprime_o[g*QW +: QW]    = qp_q;
            assign pdiv_o[g*PDW +: PDW]    = PDW'(pp_q) + PDW'(P_OFFSET);
            assign postdiv_o[g*PSW +: PSW] = PSW'(1) << m_q;

            AST_FREQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (word_stb_i && addr == AW'(g)) |=>
                (pp_q == $past(word_i[PP_LSB +: PW]) &&
                 m_q  == $past(word_i[M_LSB +: MW]) &&
                 qp_q == $past(word_i[QP_LSB +: QW]))); // R4
            AST_POSTDIV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(postdiv_o[g*PSW +: PSW]) == 1); // R6
        end
    endgenerate

    // Loads the control byte on a control-address word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (word_stb_i && addr == AW'(CTRL_ADDR))
            ctrl_q <= word_i[CTRL_LSB +: CW];
    end

    assign ctrl_o = ctrl_q;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb_i && addr == AW'(CTRL_ADDR)) |=>
        (ctrl_o == $past(word_i[CTRL_LSB +: CW]) && $stable(pprime_o) &&
         $stable(mexp_o) && $stable(qprime_o))); // R7
    AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb_i && addr >= AW'(NUM_FREQ) && addr != AW'(CTRL_ADDR)) |=>
        ($stable(pprime_o) && $stable(mexp_o) && $stable(qprime_o) &&
         $stable(ctrl_o))); // R8
    AST_INDEX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb_i && addr < AW'(NUM_FREQ) && index_fld != '0) |=>
        $stable(ctrl_o)); // R9
endmodule

// File: rtl/scp_prog_rx.sv
// Module: scp_prog_rx (top)
// Serial programming receiver: synchronizer and edge detector, unlock
// detector and word framer, address-steered register bank.
// Assumes a serial clock several system cycles per level.
module scp_prog_rx
    import scp_pkg::*;
#(
    parameter int            SYNC_STAGES = 2,
    parameter int            UNLOCK_ONES = 5,
    parameter logic [PW-1:0] DEF_PP      = 7'd25,
    parameter logic [MW-1:0] DEF_M       = 3'd2,
    parameter logic [QW-1:0] DEF_QP      = 7'd20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk_i,
    input  logic                    ser_data_i,
    output logic [NUM_FREQ*PW-1:0]  pprime_o,
    output logic [NUM_FREQ*MW-1:0]  mexp_o,
    output logic [NUM_FREQ*QW-1:0]  qprime_o,
    output logic [NUM_FREQ*PDW-1:0] pdiv_o,
    output logic [NUM_FREQ*PSW-1:0] postdiv_o,
    output logic [CW-1:0]           ctrl_o
);
    logic      bit_stb;
    logic      bit_val;
    logic      word_stb;
    dec_word_t word;

    scp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk_i),
        .ser_data_i (ser_data_i),
        .bit_stb_o  (bit_stb),
        .bit_val_o  (bit_val)
    );

    scp_frame #(.UNLOCK_ONES(UNLOCK_ONES)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb_i  (bit_stb),
        .bit_val_i  (bit_val),
        .word_stb_o (word_stb),
        .word_o     (word)
    );

    scp_reg_bank #(.DEF_PP(DEF_PP), .DEF_M(DEF_M), .DEF_QP(DEF_QP)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_stb_i (word_stb),
        .word_i     (word),
        .pprime_o   (pprime_o),
        .mexp_o     (mexp_o),
        .qprime_o   (qprime_o),
        .pdiv_o     (pdiv_o),
        .postdiv_o  (postdiv_o),
        .ctrl_o     (ctrl_o)
    );
endmodule

// File: tb/scp_prog_rx_test.sv
module scp_prog_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [20:0] pprime;
    logic [8:0]  mexp;
    logic [20:0] qprime;
    logic [23:0] pdiv;
    logic [23:0] postdiv;
    logic [7:0]  ctrl;

    int checks = 0;
    int fails  = 0;

    int exp_pp [3];
    int exp_m  [3];
    int exp_qp [3];
    int exp_ctrl;

    // Decoded word with no run of five ones, addressed to set 1.
    localparam logic [24:0] BENIGN = {3'b001, 4'b0101, 7'b0101010, 3'b010, 7'b0010101, 1'b0};

    always #2 clk = ~clk;

    scp_prog_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_data_i (ser_data),
        .pprime_o   (pprime),
        .mexp_o     (mexp),
        .qprime_o   (qprime),
        .pdiv_o     (pdiv),
        .postdiv_o  (postdiv),
        .ctrl_o     (ctrl)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compares every output with the model; waits first so all results settle.
    task automatic check_all(input string req);
        repeat (8) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(req, $sformatf("pprime[%0d]", k), int'(pprime[k*7 +: 7]), exp_pp[k]);
            chk(req, $sformatf("mexp[%0d]", k), int'(mexp[k*3 +: 3]), exp_m[k]);
            chk(req, $sformatf("qprime[%0d]", k), int'(qprime[k*7 +: 7]), exp_qp[k]);
            chk(req, $sformatf("pdiv[%0d]", k), int'(pdiv[k*8 +: 8]), exp_pp[k] + 3);
            chk(req, $sformatf("postdiv[%0d]", k), int'(postdiv[k*8 +: 8]), 1 << exp_m[k]);
        end
        chk(req, "ctrl", int'(ctrl), exp_ctrl);
    endtask

    // One serial bit: data settles, clock rises, clock holds high, clock falls.
    task automatic ser_bit(input logic b, input int hold);
        @(negedge clk);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (hold) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic unlock(input int ones);
        for (int i = 0; i < ones; i++) ser_bit(1'b1, 4);
        ser_bit(1'b0, 4);
    endtask

    task automatic send_raw(input logic [25:0] raw, input int hold);
        for (int i = 0; i < 26; i++) ser_bit(raw[i], hold);
    endtask

    // Model update for one accepted decoded word.
    task automatic model(input logic [24:0] d);
        int a;
        a = int'(d[24:22]);
        if (a < 3) begin
            exp_pp[a] = int'(d[17:11]);
            exp_m[a]  = int'(d[10:8]);
            exp_qp[a] = int'(d[7:1]);
        end else if (a == 6) begin
            exp_ctrl = int'(d[20:13]);
        end
    endtask

    function automatic logic [24:0] mk(input int a, input int idx, input int pp,
                                       input int m, input int qp, input int c);
        logic [24:0] d;
        d = '0;
        d[24:22] = 3'(a);
        if (a == 6) d[20:13] = 8'(c);
        else begin
            d[21:18] = 4'(idx);
            d[17:11] = 7'(pp);
            d[10:8]  = 3'(m);
            d[7:1]   = 7'(qp);
        end
        d[0] = 1'(idx);
        return d;
    endfunction

    task automatic send_word(input logic [24:0] d, input logic b0, input int ones, input int hold);
        unlock(ones);
        send_raw({d, b0}, hold);
        model(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            exp_pp[k] = 25; exp_m[k] = 2; exp_qp[k] = 20;
        end
        exp_ctrl = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R11");

        // R4: basic load of set 0 after a minimal unlock.
        send_word(mk(0, 3, 100, 5, 77, 0), 1'b1, 5, 4);
        check_all("R4");

        // R6 and R5: sweep M over all values across all sets.
        for (int m = 0; m < 8; m++) begin
            send_word(mk(m % 3, m, (m * 17) % 128, m, 127 - m * 9, 0), m[0], 5 + (m % 3), 4);
            check_all("R6");
        end

        // R5: P' extremes.
        send_word(mk(1, 0, 0, 1, 0, 0), 1'b0, 5, 4);
        check_all("R5");
        send_word(mk(2, 15, 127, 7, 127, 0), 1'b1, 5, 4);
        check_all("R5");

        // R3, R7, R8: every address, two field patterns each.
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 8; a++) begin
                send_word(mk(a, a + p * 7, 11 + a * 13 + p * 40, (a + p) % 8,
                             90 - a * 5 - p, 8'hA5 ^ (a * 16 + p)), p[0], 5, 4);
                if (a < 3)       check_all("R3");
                else if (a == 6) check_all("R7");
                else             check_all("R8");
            end
        end

        // R9: same fields, different index values give the same result.
        send_word(mk(0, 0, 60, 3, 33, 0), 1'b0, 5, 4);
        check_all("R9");
        send_word(mk(0, 15, 60, 3, 33, 0), 1'b1, 5, 4);
        check_all("R9");

        // R1: four ones then zero must not unlock; the benign word is ignored.
        for (int i = 0; i < 4; i++) ser_bit(1'b1, 4);
        ser_bit(1'b0, 4);
        send_raw({BENIGN, 1'b0}, 4);
        check_all("R1");
        // R1: a zero between ones restarts the count.
        for (int i = 0; i < 3; i++) ser_bit(1'b1, 4);
        ser_bit(1'b0, 4);
        for (int i = 0; i < 2; i++) ser_bit(1'b1, 4);
        send_raw({BENIGN, 1'b0}, 4);
        check_all("R1");
        // R1: a long run of ones still unlocks.
        send_word(mk(2, 4, 44, 4, 55, 0), 1'b0, 9, 4);
        check_all("R1");

        // R10: word accepted, then bits without unlock are ignored.
        send_word(mk(6, 0, 0, 0, 0, 8'h3C), 1'b0, 5, 4);
        send_raw({BENIGN, 1'b0}, 4);
        check_all("R10");

        // R2: bit 0 is dropped; two words differing only in raw bit 0.
        send_word(mk(1, 2, 19, 6, 101, 0) & 25'h1FFFFFE, 1'b1, 5, 4);
        check_all("R2");
        send_word(mk(1, 2, 19, 6, 101, 0) & 25'h1FFFFFE, 1'b0, 5, 4);
        check_all("R2");

        // R12: a serial clock held high for a long time delivers one bit.
        send_word(mk(0, 9, 88, 1, 12, 0), 1'b1, 5, 25);
        check_all("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule